// File: doc/BRIEF.md
# Link-Side Status Word Receiver

This block sits in the link controller and rebuilds status words that the physical-layer device sends across a narrow 2-bit control bus and a 2-bit data bus. Each cycle in which the control bus holds the status code carries two status bits. The block splits the incoming bit stream into two parts. The first part is a group of four event flags, and each flag becomes a one-cycle pulse as soon as its bit pair has arrived. The second part is a register record made of a 4-bit address and 8 bits of contents, and it is reported with a single strobe once the last data bits have arrived.

A transfer normally lasts 2 cycles (flags only) or 8 cycles (flags plus register record). The sender may cut a transfer short at any point when a received packet takes over the bus. Flags that were already delivered stay delivered. A partial register record is discarded, and the address and data outputs keep the last complete record. Any transfer whose length is neither 2 nor 8 cycles produces a truncation pulse, which a surrounding bench or monitor can use.

Top module: `lsr_stat_rx`

## Requirements
- R1: While reset is asserted, and after it is released with the control bus idle, every output is zero: flag pulses, register strobe, register address, register data and the truncation pulse.
- R2: A cycle counts as a status cycle only when `ctl_i` equals 2'b01. In beat k of a transfer (counting from 0), `dat_i[0]` carries status bit 2k and `dat_i[1]` carries status bit 2k+1. A cycle with any other control value delivers no bits, whatever `dat_i` holds.
- R3: In beat 0, status bit 0 (arbitration-reset gap) drives `flags_o[0]` and status bit 1 (subaction gap) drives `flags_o[1]`. Each is high for exactly the one cycle after the clock edge that samples beat 0, and only if the bit is 1.
- R4: In beat 1, status bit 2 (bus reset) drives `flags_o[2]` and status bit 3 (PHY interrupt) drives `flags_o[3]`. Each is high for exactly the one cycle after the edge that samples beat 1, and only if the bit is 1. No other beat raises a flag.
- R5: When beat 7 is sampled, `reg_vld_o` is high for exactly the next cycle. At the same time `reg_addr_o[k]` becomes status bit 4+k and `reg_data_o[k]` becomes status bit 8+k.
- R6: A transfer that ends after 3 to 7 beats raises no `reg_vld_o`, and `reg_addr_o`/`reg_data_o` keep the last complete record. Flags pulsed in beats 0 and 1 of that transfer are not withdrawn.
- R7: When the first non-status cycle follows a transfer of L beats, `trunc_o` is high for exactly the next cycle if L is neither 2 nor 8. For L = 2 or L = 8 it stays low.
- R8: Every non-status cycle restarts beat counting, so a transfer that begins after a truncated one decodes from bit 0 again.
- R9: Status cycles beyond beat 7 raise no flag and no second `reg_vld_o`. A transfer of that length counts as truncated under R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_i | input | 2 | Control bus; 2'b01 marks a status cycle |
| dat_i | input | 2 | Data bus; bit 0 carries the even status bit |
| flags_o | output | 4 | One-cycle flag pulses: arb-reset gap, subaction gap, bus reset, interrupt |
| reg_vld_o | output | 1 | One-cycle strobe for a complete register record |
| reg_addr_o | output | 4 | Address of the last complete record |
| reg_data_o | output | 8 | Contents of the last complete record |
| trunc_o | output | 1 | One-cycle pulse after a transfer of irregular length |

## Verification
The bench cuts transfers off after one beat and in the middle of the register record. A design that waited for the whole transfer before releasing flags would lose the beat-0 pulses. A design that published partial records would overwrite the address and data outputs. It also sends a truncated transfer followed directly by a full one, which exposes a beat counter that does not clear. It also sends a transfer that runs past eight beats, which exposes a second strobe or stray flags. Idle cycles carry non-status control codes with ones on the data bus, which catches a decoder that looks at only one control line.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  localparam int unsigned LSR_BPC    = 2;
  localparam int unsigned LSR_FLAGS  = 4;
  localparam int unsigned LSR_ADDR_W = 4;
  localparam int unsigned LSR_DATA_W = 8;
  localparam logic [1:0]  LSR_CTL_STATUS = 2'b01;

  // number of bus beats needed to carry a given number of bits
  function automatic int unsigned lsr_beats(input int unsigned bits,
                                            input int unsigned bpc);
    return (bits + bpc - 1) / bpc;
  endfunction

  // beat index on which a flag bit travels
  function automatic int unsigned lsr_flag_beat(input int unsigned flag_idx,
                                                input int unsigned bpc);
    return flag_idx / bpc;
  endfunction

  // lane of the data bus that carries a flag bit
  function automatic int unsigned lsr_flag_lane(input int unsigned flag_idx,
                                                input int unsigned bpc);
    return flag_idx % bpc;
  endfunction

  // a transfer length is regular when it is the short or the full form
  function automatic logic lsr_len_regular(input int unsigned len,
                                           input int unsigned short_len,
                                           input int unsigned full_len);
    return (len == short_len) || (len == full_len);
  endfunction

endpackage

// File: rtl/lsr_beat_ctr.sv
module lsr_beat_ctr #(
  parameter int unsigned FULL_CYC = 8,
  parameter int unsigned CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_act,
  output logic [CNT_W-1:0] beat_idx,
  output logic             end_evt,
  output logic [CNT_W-1:0] end_len
);

  // saturates one past the full length so overlong transfers stay visible
  localparam logic [CNT_W-1:0] SAT = CNT_W'(FULL_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (stat_act) begin
      if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign beat_idx = cnt_q;
  assign end_evt  = !stat_act && (cnt_q != '0);
  assign end_len  = cnt_q;

endmodule

// File: rtl/lsr_flag_pulse.sv
module lsr_flag_pulse
  import lsr_pkg::*;
#(
  parameter int unsigned BPC   = 2,
  parameter int unsigned FLAGS = 4,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_act,
  input  logic [CNT_W-1:0] beat_idx,
  input  logic [BPC-1:0]   dat,
  output logic [FLAGS-1:0] flags
);

  logic [FLAGS-1:0] flag_q;

  for (genvar g = 0; g < FLAGS; g++) begin : g_flag
    localparam int unsigned BEAT = lsr_flag_beat(g, BPC);
    localparam int unsigned LANE = lsr_flag_lane(g, BPC);
    logic hit;
    assign hit = stat_act && (beat_idx == CNT_W'(BEAT)) && dat[LANE];
    always_ff @(posedge clk) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= hit;
    end
  end

  assign flags = flag_q;

endmodule

// File: rtl/lsr_reg_asm.sv
module lsr_reg_asm #(
  parameter int unsigned BPC      = 2,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FLAG_CYC = 2,
  parameter int unsigned FULL_CYC = 8,
  parameter int unsigned CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_act,
  input  logic [CNT_W-1:0]  beat_idx,
  input  logic [BPC-1:0]    dat,
  output logic              last_beat,
  output logic              reg_vld,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_data
);

  localparam int unsigned PAY_W = ADDR_W + DATA_W;

  logic [PAY_W-1:0]  pay_q;
  logic [PAY_W-1:0]  pay_next;
  logic              in_pay;
  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // new bits enter at the top; the first payload beat ends at the bottom
  assign pay_next  = {dat, pay_q[PAY_W-1:BPC]};
  assign in_pay    = stat_act && (beat_idx >= CNT_W'(FLAG_CYC))
                              && (beat_idx <  CNT_W'(FULL_CYC));
  assign last_beat = stat_act && (beat_idx == CNT_W'(FULL_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pay_q <= '0;
    end else if (in_pay) begin
      pay_q <= pay_next;
    end else if (!stat_act) begin
      pay_q <= '0;  // partial record discarded
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      vld_q <= last_beat;
      if (last_beat) begin
        addr_q <= pay_next[ADDR_W-1:0];
        data_q <= pay_next[PAY_W-1:ADDR_W];
      end
    end
  end

  assign reg_vld  = vld_q;
  assign reg_addr = addr_q;
  assign reg_data = data_q;

endmodule

// File: rtl/lsr_stat_rx.sv
module lsr_stat_rx
  import lsr_pkg::*;
#(
  parameter int unsigned BPC    = LSR_BPC,
  parameter int unsigned FLAGS  = LSR_FLAGS,
  parameter int unsigned ADDR_W = LSR_ADDR_W,
  parameter int unsigned DATA_W = LSR_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctl_i,
  input  logic [BPC-1:0]    dat_i,
  output logic [FLAGS-1:0]  flags_o,
  output logic              reg_vld_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_data_o,
  output logic              trunc_o
);

  localparam int unsigned FLAG_CYC = lsr_beats(FLAGS, BPC);
  localparam int unsigned FULL_CYC = lsr_beats(FLAGS + ADDR_W + DATA_W, BPC);
  localparam int unsigned CNT_W    = $clog2(FULL_CYC + 2);

  // named internal events, visible to the bound checker
  logic             stat_act;
  logic [CNT_W-1:0] beat_idx;
  logic             end_evt;
  logic [CNT_W-1:0] end_len;
  logic             last_beat;
  logic             end_irregular;
  logic             trunc_q;

  assign stat_act = (ctl_i == LSR_CTL_STATUS);

  lsr_beat_ctr #(.FULL_CYC(FULL_CYC), .CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_act (stat_act),
    .beat_idx (beat_idx),
    .end_evt  (end_evt),
    .end_len  (end_len)
  );

  lsr_flag_pulse #(.BPC(BPC), .FLAGS(FLAGS), .CNT_W(CNT_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_act (stat_act),
    .beat_idx (beat_idx),
    .dat      (dat_i),
    .flags    (flags_o)
  );

  lsr_reg_asm #(
    .BPC(BPC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FLAG_CYC(FLAG_CYC), .FULL_CYC(FULL_CYC), .CNT_W(CNT_W)
  ) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_act  (stat_act),
    .beat_idx  (beat_idx),
    .dat       (dat_i),
    .last_beat (last_beat),
    .reg_vld   (reg_vld_o),
    .reg_addr  (reg_addr_o),
    .reg_data  (reg_data_o)
  );

  assign end_irregular = end_evt && !lsr_len_regular(32'(end_len), FLAG_CYC, FULL_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n) trunc_q <= 1'b0;
    else        trunc_q <= end_irregular;
  end

  assign trunc_o = trunc_q;

endmodule

// File: rtl/lsr_stat_rx_chk.sv
module lsr_stat_rx_chk #(
  parameter int unsigned FLAGS    = 4,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FLAG_CYC = 2,
  parameter int unsigned FULL_CYC = 8,
  parameter int unsigned CNT_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        ctl_i,
  input logic [FLAGS-1:0]  flags_o,
  input logic              reg_vld_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic [DATA_W-1:0] reg_data_o,
  input logic              trunc_o,
  input logic [CNT_W-1:0]  beat_idx
);

  // R8: leaving the status code clears the beat count
  a_r8_count_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i != 2'b01) |=> (beat_idx == '0));

  // R3: the first flag only follows a sampled beat 0
  a_r3_flag0_beat0: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[0] |-> ($past(ctl_i) == 2'b01) && ($past(beat_idx) == '0));

  // R4 / R9: flags only follow status beats inside the flag window
  a_r4_flag_window: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o != '0) |-> ($past(ctl_i) == 2'b01)
                     && ($past(beat_idx) < CNT_W'(FLAG_CYC)));

  // R5 / R9: the record strobe only follows the final payload beat
  a_r5_vld_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    reg_vld_o |-> ($past(ctl_i) == 2'b01)
               && ($past(beat_idx) == CNT_W'(FULL_CYC - 1)));

  // R6: record outputs change only together with the strobe
  a_r6_record_held: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_vld_o |-> $stable(reg_addr_o) && $stable(reg_data_o));

  // R7: truncation is reported only after a non-status cycle
  a_r7_trunc_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_o |-> ($past(ctl_i) != 2'b01) && ($past(beat_idx) != '0));

  // R7: strobe and truncation never coincide
  a_r7_trunc_vld_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(trunc_o && reg_vld_o));

endmodule

bind lsr_stat_rx lsr_stat_rx_chk #(
  .FLAGS(FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .FLAG_CYC(FLAG_CYC), .FULL_CYC(FULL_CYC), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_i      (ctl_i),
  .flags_o    (flags_o),
  .reg_vld_o  (reg_vld_o),
  .reg_addr_o (reg_addr_o),
  .reg_data_o (reg_data_o),
  .trunc_o    (trunc_o),
  .beat_idx   (beat_idx)
);

// File: tb/lsr_stat_rx_tb.sv
module lsr_stat_rx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ctl = 2'b00;
  logic [1:0] dat = 2'b00;
  logic [3:0] flags_o;
  logic       reg_vld_o;
  logic [3:0] reg_addr_o;
  logic [7:0] reg_data_o;
  logic       trunc_o;

  always #10 clk = ~clk;  // 50 MHz

  lsr_stat_rx u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .dat_i(dat),
    .flags_o(flags_o), .reg_vld_o(reg_vld_o), .reg_addr_o(reg_addr_o),
    .reg_data_o(reg_data_o), .trunc_o(trunc_o)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  logic [3:0] e_flags = '0;
  logic       e_vld   = 1'b0;
  logic       e_trunc = 1'b0;
  logic [3:0] e_addr  = '0;
  logic [7:0] e_data  = '0;

  task automatic chk(input string rq, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic sample(input string rq);
    chk(rq, "flags",    16'(flags_o),    16'(e_flags));
    chk(rq, "reg_vld",  16'(reg_vld_o),  16'(e_vld));
    chk(rq, "trunc",    16'(trunc_o),    16'(e_trunc));
    chk(rq, "reg_addr", 16'(reg_addr_o), 16'(e_addr));
    chk(rq, "reg_data", 16'(reg_data_o), 16'(e_data));
  endtask

  // one transfer of nb beats carrying word w, then one idle cycle
  task automatic xfer(input string rq, input logic [15:0] w, input int nb,
                      input logic [1:0] idle_ctl, input logic [1:0] idle_dat);
    for (int b = 0; b <= nb; b++) begin
      @(negedge clk);
      sample(rq);
      if (b < nb) begin
        ctl = 2'b01;
        dat = (b < 8) ? {w[2*b+1], w[2*b]} : 2'b11;
        e_flags = (b == 0) ? {2'b00, w[1], w[0]} :
                  (b == 1) ? {w[3], w[2], 2'b00} : 4'b0000;
        e_vld   = (b == 7);
        if (b == 7) begin
          e_addr = w[7:4];
          e_data = w[15:8];
        end
        e_trunc = 1'b0;
      end else begin
        ctl = idle_ctl;
        dat = idle_dat;
        e_flags = '0;
        e_vld   = 1'b0;
        e_trunc = (nb != 2) && (nb != 8);
      end
    end
    @(negedge clk);
    sample(rq);
    e_trunc = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    sample("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    sample("R1 after release");
  endtask

  // non-status control codes with ones on the data bus deliver nothing
  task automatic t_noise;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      sample("R2 noise");
      ctl = (k == 0) ? 2'b00 : (k == 1) ? 2'b10 : 2'b11;
      dat = 2'b11;
    end
    @(negedge clk);
    sample("R2 noise end");
  endtask

  task automatic t_flags_only;
    xfer("R3 R4 all flags",   16'h000F, 2, 2'b00, 2'b00);
    xfer("R3 R4 mixed flags", 16'h0006, 2, 2'b11, 2'b11);
    xfer("R3 R4 zero flags",  16'hFFF0, 2, 2'b10, 2'b01);
  endtask

  task automatic t_full;
    xfer("R5 full A5C9", 16'hA5C9, 8, 2'b00, 2'b00);
    xfer("R5 full 3C5A", 16'h3C5A, 8, 2'b11, 2'b10);
  endtask

  task automatic t_trunc;
    xfer("R6 R7 cut at 5", 16'hFFFF, 5, 2'b00, 2'b00);
    xfer("R7 cut at 1",    16'h0003, 1, 2'b10, 2'b11);
    xfer("R6 R7 cut at 7", 16'h81BE, 7, 2'b00, 2'b00);
  endtask

  task automatic t_restart;
    xfer("R8 cut at 3",        16'hF00D, 3, 2'b00, 2'b00);
    xfer("R8 full after cut",  16'h96E1, 8, 2'b00, 2'b00);
  endtask

  task automatic t_overlong;
    xfer("R9 overlong", 16'h1234, 10, 2'b00, 2'b00);
    xfer("R9 after overlong", 16'h000A, 2, 2'b00, 2'b00);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_noise();
    t_flags_only();
    t_full();
    t_trunc();
    t_restart();
    t_overlong();
    repeat (2) @(negedge clk);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

endmodule